// File: doc/BRIEF.md
# DAC Sample Formatter with Cyclic Prefix Insertion

This block sits between an OFDM transmit pipeline and the serializer that feeds a high-speed digital-to-analogue converter. Time-domain samples arrive several per clock as one wide word, grouped into symbols of a fixed length. The block keeps one whole symbol in a buffer. It then plays that symbol back with a copy of its tail placed in front, the cyclic prefix. A symbol that is flagged as the start of a frame is preceded by a preamble taken from a small writable memory.

Every outgoing sample, from the preamble or from a symbol, is reduced from the 16-bit input resolution to the 12-bit converter resolution. The reduction rounds half up and saturates at the signed limits. The result is then sent either as two's complement or as offset binary. When nothing is being played, every output lane carries the encoded zero level, so the converter rests at mid-scale.

The prefix length and the frame flag travel with the first word of each symbol. The upstream stage can therefore change them from one symbol to the next without stopping the stream.

Top module: `dac_sample_formatter`

## Requirements
- R1: While reset is asserted and whenever no word is being played, `outValid` is 0 and every output lane holds the encoded zero (0x000 in two's complement, 0x800 in offset binary). After reset `inReady` is 1.
- R2: A symbol whose first input word had `inFirst`=1 is preceded by PRE_WORDS output words read from the preamble memory in address order. Lane j of address a is the sample stored there by the write port. These samples are formatted like data.
- R3: With prefix length c, a symbol's output is its last c samples followed by all SYM_LEN samples, in sample order. The prefix starts in lane 0. The symbol occupies ceil((c+SYM_LEN)/LANES) words, and any unused lanes of the last word carry encoded zero.
- R4: A prefix length of 0 gives no prefix. A value above MAX_CP is treated as MAX_CP.
- R5: Each 16-bit sample x becomes floor((x+8)/16), limited to the range -2048..2047.
- R6: When `fmtBinary`=0 the 12-bit result is sent as two's complement. When it is 1 the most significant bit is inverted (offset binary). The setting applies to the word registered at the next clock edge.
- R7: `inReady` is 0 while a preamble is played and during the prefix words of a symbol. If input is offered every cycle, symbols without a preamble leave the block back to back with no idle word between them, and no input word is lost.
- R8: `cpLen` and `inFirst` are sampled only with the first word of each symbol. Their values on the other words have no effect.
- R9: Sample lane j occupies bits [j*16 +: 16] of the input and preamble words, and bits [j*12 +: 12] of `outData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word offered |
| inFirst | input | 1 | With the first word of a symbol: put the preamble in front |
| inData | input | LANES*16 | Input samples, signed, lane 0 lowest |
| cpLen | input | clog2(MAX_CP+1) | Prefix length in samples, taken with the first word of a symbol |
| inReady | output | 1 | Input word is accepted when both this and inValid are 1 |
| preWrEn | input | 1 | Preamble memory write strobe |
| preWrAddr | input | max(1,clog2(PRE_WORDS)) | Preamble word address |
| preWrData | input | LANES*16 | Preamble samples for one word |
| fmtBinary | input | 1 | 0: two's complement, 1: offset binary |
| outValid | output | 1 | outData carries a preamble or symbol word |
| outData | output | LANES*12 | Converter samples, lane 0 lowest |

## Verification
The checker assumes that reset is high from the first clock edge. Its idle-level property compares the output against the format input as it stood one edge earlier, so `fmtBinary` may change at any time. The prefix-stall and preamble-length properties work from the controller's latched prefix length and rely only on the clamping of R4. The stimulus writes the preamble before the first framed symbol. It changes the number format only while the block is idle, so every expected word has a single encoding. It drives out-of-range prefix lengths and junk values on non-first words only in order to exercise R4 and R8.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  // Strobes from the sequencer to the datapath; counters zero-extended to 16 bits.
  typedef struct packed {
    logic        bufWr;
    logic [15:0] wrWord;
    logic        showPre;
    logic [15:0] preWord;
    logic        showSym;
    logic [15:0] symWord;
    logic [15:0] cp;
  } dsf_strb_t;

endpackage

// File: rtl/dsf_ctrl.sv
module dsf_ctrl
  import dsf_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int SYM_LEN   = 64,
  parameter int MAX_CP    = 16,
  parameter int PRE_WORDS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             inValid,
  input  logic                             inFirst,
  input  logic [$clog2(MAX_CP+1)-1:0]      cpLen,
  output logic                             inReady,
  output dsf_strb_t                        strb
);

  localparam int WORDS  = SYM_LEN / LANES;
  localparam int CPW    = $clog2(MAX_CP + 1);
  localparam int WCW    = $clog2(WORDS + 1);
  localparam int PCW    = $clog2(PRE_WORDS + 1);
  localparam int MAXT   = (MAX_CP + LANES - 1) / LANES + WORDS;
  localparam int KW     = $clog2(MAXT + 1);

  typedef enum logic [1:0] {ST_FILL, ST_PRE, ST_SYM} st_t;

  st_t            st, stNext;
  logic [WCW-1:0] wrCnt, wrCntNext, wrCntInc;
  logic [KW-1:0]  symWord, symWordNext, prefWords, lastWord;
  logic [PCW-1:0] preWord, preWordNext;
  logic [CPW-1:0] cpCur, cpCurNext, cpPend, cpPendNext, cpClamp;
  logic           framePend, framePendNext;
  logic           accept, fullNext, launch;

  assign cpClamp   = (cpLen > CPW'(MAX_CP)) ? CPW'(MAX_CP) : cpLen;
  assign prefWords = KW'((int'(cpCur) + LANES - 1) / LANES);
  assign lastWord  = KW'((int'(cpCur) + LANES - 1) / LANES + WORDS - 1);

  // Input is taken while filling, or once the prefix words of the playing symbol are out.
  assign inReady = (wrCnt != WCW'(WORDS)) &&
                   ((st == ST_FILL) || (st == ST_SYM && symWord >= prefWords));
  assign accept  = inValid && inReady;

  assign wrCntInc      = wrCnt + WCW'(accept);
  assign fullNext      = (wrCntInc == WCW'(WORDS));
  assign cpPendNext    = (accept && wrCnt == '0) ? cpClamp : cpPend;
  assign framePendNext = (accept && wrCnt == '0) ? inFirst : framePend;
  assign launch        = (st == ST_FILL && wrCnt == WCW'(WORDS)) ||
                         (st == ST_SYM && symWord == lastWord && fullNext);

  always_comb begin
    stNext      = st;
    wrCntNext   = wrCntInc;
    symWordNext = symWord;
    preWordNext = preWord;
    cpCurNext   = cpCur;
    case (st)
      ST_PRE: begin
        preWordNext = preWord + PCW'(1);
        if (preWord == PCW'(PRE_WORDS - 1)) begin
          stNext      = ST_SYM;
          symWordNext = '0;
        end
      end
      ST_SYM: begin
        symWordNext = symWord + KW'(1);
        if (symWord == lastWord) stNext = ST_FILL;
      end
      default: ;
    endcase
    if (launch) begin
      wrCntNext   = '0;
      cpCurNext   = cpPendNext;
      symWordNext = '0;
      preWordNext = '0;
      stNext      = framePendNext ? ST_PRE : ST_SYM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_FILL;
      wrCnt     <= '0;
      symWord   <= '0;
      preWord   <= '0;
      cpCur     <= '0;
      cpPend    <= '0;
      framePend <= 1'b0;
    end else begin
      st        <= stNext;
      wrCnt     <= wrCntNext;
      symWord   <= symWordNext;
      preWord   <= preWordNext;
      cpCur     <= cpCurNext;
      cpPend    <= cpPendNext;
      framePend <= framePendNext;
    end
  end

  always_comb begin
    strb.bufWr   = accept;
    strb.wrWord  = 16'(wrCnt);
    strb.showPre = (st == ST_PRE);
    strb.preWord = 16'(preWord);
    strb.showSym = (st == ST_SYM);
    strb.symWord = 16'(symWord);
    strb.cp      = 16'(cpCur);
  end

endmodule

// File: rtl/dsf_datapath.sv
module dsf_datapath
  import dsf_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int IN_W      = 16,
  parameter int OUT_W     = 12,
  parameter int SYM_LEN   = 64,
  parameter int PRE_WORDS = 4,
  parameter int PAW       = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  dsf_strb_t              strb,
  input  logic [LANES*IN_W-1:0]  inData,
  input  logic                   preWrEn,
  input  logic [PAW-1:0]         preWrAddr,
  input  logic [LANES*IN_W-1:0]  preWrData,
  input  logic                   fmtBinary,
  output logic                   outValid,
  output logic [LANES*OUT_W-1:0] outData
);

  localparam int SH   = IN_W - OUT_W;
  localparam int QW   = OUT_W + 1;
  localparam int BIW  = $clog2(SYM_LEN);
  localparam int PSW  = $clog2(PRE_WORDS * LANES);
  localparam logic signed [IN_W:0] HALF = (IN_W + 1)'(1) << (SH - 1);
  localparam logic signed [QW-1:0] QMAX = QW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [QW-1:0] QMIN = ~QMAX;
  localparam logic [OUT_W-1:0]     MSB  = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] symBuf [SYM_LEN];
  logic signed [IN_W-1:0] preMem [PRE_WORDS*LANES];
  logic [OUT_W-1:0]       fmtLane [LANES];

  // Round half up, saturate, then pick the number format.
  function automatic logic [OUT_W-1:0] encodeSample(input logic signed [IN_W-1:0] x,
                                                    input logic bin);
    logic signed [IN_W:0] ext;
    logic signed [QW-1:0] q;
    logic [OUT_W-1:0]     c;
    ext = $signed({x[IN_W-1], x}) + HALF;
    q   = QW'(ext >>> SH);
    if (q > QMAX)      c = QMAX[OUT_W-1:0];
    else if (q < QMIN) c = QMIN[OUT_W-1:0];
    else               c = q[OUT_W-1:0];
    return bin ? (c ^ MSB) : c;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.bufWr)
      for (int j = 0; j < LANES; j++)
        symBuf[BIW'(int'(strb.wrWord) * LANES + j)] <= inData[j*IN_W +: IN_W];
    if (preWrEn)
      for (int j = 0; j < LANES; j++)
        preMem[PSW'(int'(preWrAddr) * LANES + j)] <= preWrData[j*IN_W +: IN_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [IN_W-1:0] raw;
    int                     pos;
    int                     cpI;
    always_comb begin
      pos = int'(strb.symWord) * LANES + g;
      cpI = int'(strb.cp);
      raw = '0;
      if (strb.showPre)
        raw = preMem[PSW'(int'(strb.preWord) * LANES + g)];
      else if (strb.showSym) begin
        if (pos < cpI)                raw = symBuf[BIW'(SYM_LEN - cpI + pos)];
        else if (pos < cpI + SYM_LEN) raw = symBuf[BIW'(pos - cpI)];
      end
    end
    assign fmtLane[g] = encodeSample(raw, fmtBinary);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= {LANES{fmtBinary ? MSB : {OUT_W{1'b0}}}};
    end else begin
      outValid <= strb.showPre || strb.showSym;
      for (int j = 0; j < LANES; j++) outData[j*OUT_W +: OUT_W] <= fmtLane[j];
    end
  end

endmodule

// File: rtl/dac_sample_formatter.sv
module dac_sample_formatter
  import dsf_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int IN_W      = 16,
  parameter int OUT_W     = 12,
  parameter int SYM_LEN   = 64,
  parameter int MAX_CP    = 16,
  parameter int PRE_WORDS = 4
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           inValid,
  input  logic                                           inFirst,
  input  logic [LANES*IN_W-1:0]                          inData,
  input  logic [$clog2(MAX_CP+1)-1:0]                    cpLen,
  output logic                                           inReady,
  input  logic                                           preWrEn,
  input  logic [((PRE_WORDS>1)?$clog2(PRE_WORDS):1)-1:0] preWrAddr,
  input  logic [LANES*IN_W-1:0]                          preWrData,
  input  logic                                           fmtBinary,
  output logic                                           outValid,
  output logic [LANES*OUT_W-1:0]                         outData
);

  localparam int PAW = (PRE_WORDS > 1) ? $clog2(PRE_WORDS) : 1;

  dsf_strb_t strb;

  dsf_ctrl #(
    .LANES(LANES), .SYM_LEN(SYM_LEN), .MAX_CP(MAX_CP), .PRE_WORDS(PRE_WORDS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inFirst(inFirst),
    .cpLen(cpLen), .inReady(inReady), .strb(strb)
  );

  dsf_datapath #(
    .LANES(LANES), .IN_W(IN_W), .OUT_W(OUT_W), .SYM_LEN(SYM_LEN),
    .PRE_WORDS(PRE_WORDS), .PAW(PAW)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .inData(inData),
    .preWrEn(preWrEn), .preWrAddr(preWrAddr), .preWrData(preWrData),
    .fmtBinary(fmtBinary), .outValid(outValid), .outData(outData)
  );

endmodule

// File: rtl/dac_sample_formatter_chk.sv
module dac_sample_formatter_chk
  import dsf_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int OUT_W     = 12,
  parameter int MAX_CP    = 16,
  parameter int PRE_WORDS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   inReady,
  input logic                   fmtBinary,
  input logic                   outValid,
  input logic [LANES*OUT_W-1:0] outData,
  input dsf_strb_t              strb
);

  localparam logic [OUT_W-1:0] MSB = {1'b1, {(OUT_W-1){1'b0}}};

  int preRun;
  always_ff @(posedge clk) begin
    if (rst) preRun <= 0;
    else     preRun <= strb.showPre ? preRun + 1 : 0;
  end

  // R1: idle words carry the encoded zero of the format in force one edge earlier
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> outData == {LANES{$past(fmtBinary) ? MSB : {OUT_W{1'b0}}}});

  // R7: no input taken while a preamble plays
  a_r7_ready_low_pre: assert property (@(posedge clk) disable iff (rst)
    strb.showPre |-> !inReady);

  // R7: input taken during playout only after the prefix words
  a_r7_ready_after_prefix: assert property (@(posedge clk) disable iff (rst)
    (strb.showSym && inReady) |->
      (int'(strb.symWord) >= (int'(strb.cp) + LANES - 1) / LANES));

  // R2: a preamble run lasts PRE_WORDS words and is followed by symbol playout
  a_r2_pre_then_sym: assert property (@(posedge clk) disable iff (rst)
    $fell(strb.showPre) |-> (strb.showSym && preRun == PRE_WORDS));

  // R4: latched prefix length never exceeds the maximum
  a_r4_cp_bound: assert property (@(posedge clk) disable iff (rst)
    int'(strb.cp) <= MAX_CP);

  // R1: output valid follows the playout strobes by one register
  a_r1_valid_track: assert property (@(posedge clk) disable iff (rst)
    outValid == $past(strb.showPre || strb.showSym));

endmodule

bind dac_sample_formatter dac_sample_formatter_chk #(
  .LANES(LANES), .OUT_W(OUT_W), .MAX_CP(MAX_CP), .PRE_WORDS(PRE_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .fmtBinary(fmtBinary),
  .outValid(outValid), .outData(outData), .strb(strb)
);

// File: tb/dac_sample_formatter_tb.sv
module dac_sample_formatter_tb;

  localparam int LANES = 4, IN_W = 16, OUT_W = 12, SYM_LEN = 32, MAX_CP = 16, PRE_WORDS = 2;
  localparam int WORDS = SYM_LEN / LANES;
  localparam int SH = IN_W - OUT_W;

  logic clk = 0, rst = 1, inValid = 0, inFirst = 0, inReady, preWrEn = 0, fmtBinary = 0, outValid;
  logic [LANES*IN_W-1:0]  inData = '0, preWrData = '0;
  logic [4:0]             cpLen = '0;
  logic [0:0]             preWrAddr = '0;
  logic [LANES*OUT_W-1:0] outData;

  int checks = 0, errors = 0, cyc = 0;
  logic [LANES*OUT_W-1:0] expQ[$];
  string                  tagQ[$];
  bit winOn = 0;
  int vCnt = 0, firstCyc = 0, lastCyc = 0;

  dac_sample_formatter #(.LANES(LANES), .IN_W(IN_W), .OUT_W(OUT_W), .SYM_LEN(SYM_LEN),
                         .MAX_CP(MAX_CP), .PRE_WORDS(PRE_WORDS)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inFirst(inFirst), .inData(inData),
    .cpLen(cpLen), .inReady(inReady), .preWrEn(preWrEn), .preWrAddr(preWrAddr),
    .preWrData(preWrData), .fmtBinary(fmtBinary), .outValid(outValid), .outData(outData));

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  // R5 R6: arithmetic model of rounding, saturation and format
  function automatic logic [OUT_W-1:0] enc(int x, bit bin);
    int r;
    r = (x + (1 << (SH - 1))) >>> SH;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return OUT_W'(r) ^ (bin ? 12'h800 : 12'h000);
  endfunction

  function automatic int smp(int sym, int i);
    case (i)
      0: return 32767;  1: return -32768; 2: return 32759; 3: return 32760;
      4: return -8;     5: return -9;     6: return 7;
      default: return ((sym * 977 + i * 331) % 65536) - 32768;
    endcase
  endfunction

  function automatic int preVal(int a, int j);
    if (a == 0) return (j == 0) ? 32767 : (j == 1) ? -32768 : (j == 2) ? 100 : -100;
    return 1000 * j - 1477;
  endfunction

  task automatic check(bit ok, string req, logic [LANES*OUT_W-1:0] got, logic [LANES*OUT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (winOn) begin
        if (vCnt == 0) firstCyc = cyc;
        lastCyc = cyc;
        vCnt++;
      end
      if (expQ.size() == 0) check(0, "R1 unexpected valid word", outData, '0);
      else begin
        logic [LANES*OUT_W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outData == e, t, outData, e);
      end
    end
  end

  task automatic pushSymbol(int sym, int cp, bit first, bit bin);
    int c, p;
    logic [LANES*OUT_W-1:0] w;
    c = (cp > MAX_CP) ? MAX_CP : cp;
    p = (c + LANES - 1) / LANES;
    if (first)
      for (int a = 0; a < PRE_WORDS; a++) begin
        for (int j = 0; j < LANES; j++) w[j*OUT_W +: OUT_W] = enc(preVal(a, j), bin);
        expQ.push_back(w); tagQ.push_back("R2 R5 R6 R9 preamble");
      end
    for (int k = 0; k < p + WORDS; k++) begin
      for (int j = 0; j < LANES; j++) begin
        int s, v;
        s = k * LANES + j;
        if (s < c)                v = smp(sym, SYM_LEN - c + s);
        else if (s < c + SYM_LEN) v = smp(sym, s - c);
        else                      v = 0;
        w[j*OUT_W +: OUT_W] = enc(v, bin);
      end
      expQ.push_back(w);
      tagQ.push_back((cp > MAX_CP) ? "R4 R3 R5 R6 R8 R9 clamped symbol" : "R3 R4 R5 R6 R8 R9 symbol");
    end
  endtask

  // R8: cpLen and inFirst carry junk on every word except the first
  task automatic sendSymbol(int sym, int cp, bit first, bit bin, bit gap);
    pushSymbol(sym, cp, first, bin);
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      if (gap && (w % 2 == 1)) begin inValid = 0; @(negedge clk); end
      inValid = 1;
      inFirst = (w == 0) ? first : ~first;
      cpLen   = (w == 0) ? 5'(cp) : 5'(31 - cp);
      for (int j = 0; j < LANES; j++) inData[j*IN_W +: IN_W] = IN_W'(smp(sym, w * LANES + j));
      while (!inReady) @(negedge clk);
    end
  endtask

  task automatic drainIdle(bit bin, string req);
    @(negedge clk); inValid = 0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(outValid == 0 && outData == {LANES{bin ? 12'h800 : 12'h000}}, req, outData,
          {LANES{bin ? 12'h800 : 12'h000}});
    check(inReady == 1, "R1 ready when idle", {47'b0, inReady}, 48'd1);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(outValid == 0 && outData == '0, "R1 reset two's complement zero", outData, '0);
    check(inReady == 1, "R1 ready after reset", {47'b0, inReady}, 48'd1);

    for (int a = 0; a < PRE_WORDS; a++) begin
      @(negedge clk);
      preWrEn = 1; preWrAddr = 1'(a);
      for (int j = 0; j < LANES; j++) preWrData[j*IN_W +: IN_W] = IN_W'(preVal(a, j));
    end
    @(negedge clk); preWrEn = 0;

    // Sweep every prefix length plus two out-of-range ones, two's complement
    for (int cp = 0; cp <= MAX_CP + 2; cp++) begin
      int cv;
      cv = (cp == MAX_CP + 1) ? 20 : (cp == MAX_CP + 2) ? 31 : cp;
      sendSymbol(cp, cv, (cp % 4 == 0), 0, 0);
    end
    drainIdle(0, "R1 idle zero two's complement");

    // Same sweep in offset binary, with input gaps
    fmtBinary = 1;
    for (int cp = 0; cp <= MAX_CP; cp++) sendSymbol(cp + 40, cp, (cp % 5 == 1), 1, (cp % 2 == 0));
    drainIdle(1, "R1 R6 idle zero offset binary");

    // R7: continuous input, no preamble: output must be gap-free
    fmtBinary = 0;
    @(negedge clk);
    winOn = 1; vCnt = 0;
    for (int s = 0; s < 4; s++) sendSymbol(s + 90, 9, 0, 0, 0);
    drainIdle(0, "R1 idle after stream");
    winOn = 0;
    check(vCnt == 4 * (3 + WORDS), "R7 output word count", 48'(vCnt), 48'(4 * (3 + WORDS)));
    check(lastCyc - firstCyc + 1 == vCnt, "R7 back-to-back output", 48'(lastCyc - firstCyc + 1), 48'(vCnt));

    // R1: reset in offset binary loads the binary zero level
    @(negedge clk); fmtBinary = 1; rst = 1;
    repeat (3) @(negedge clk);
    check(outValid == 0 && outData == {LANES{12'h800}}, "R1 reset offset binary zero", outData, {LANES{12'h800}});
    rst = 0;
    @(negedge clk);
    check(outValid == 0 && outData == {LANES{12'h800}}, "R1 after reset offset binary", outData, {LANES{12'h800}});

    // Preamble memory persists across reset; framed symbols with prefix lengths 0 and 16
    sendSymbol(200, 0, 1, 1, 0);
    sendSymbol(201, MAX_CP, 1, 1, 0);
    drainIdle(1, "R1 final idle");

    finishRun();
  end

endmodule